// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit holds the event flags of a bus-master serial controller and presents them to a host through a small register window. A bus engine raises flags with one-cycle set pulses. The host reads the flags, masks them, clears them, and optionally routes the two data-ready flags to DMA request lines. The unit drives one level interrupt line and two DMA requests from the stored state.

A synthesis parameter picks one of two register revisions. The older revision has a 5-bit enable mask and a vector register. Reading the vector register acknowledges the lowest-numbered pending enabled flag. The newer revision has a 6-bit mask and no vector register. Instead it clears flags when the host writes ones to the status register, and it has a self-test write that forces the low six flags on.

Top module: `irq_status_vector`

## Requirements
- R1: `irq` is high exactly when (status bits 5..0 AND enable mask) is non-zero. It is registered: it reflects register contents one cycle after they change, so it follows a set pulse two clock edges after the pulse.
- R2: `drq_rx` equals DMA-enable bit 15 AND status bit 3. `drq_tx` equals DMA-enable bit 7 AND status bit 4. Both are registered with the same one-cycle lag as `irq`.
- R3: Reading select code 2 (vector) in the older revision returns the index plus one of the lowest set bit of (status AND mask), or 0 when none is set, and clears that status bit. In the newer revision the read returns 0 and changes nothing.
- R4: Writing select code 3 (DMA enable) stores only bits 15 and 7. A write with bit 15 set clears mask bit 3, and a write with bit 7 set clears mask bit 4.
- R5: Writing select code 1 (status) in the newer revision clears the status bits where the written data AND 0x0027 is one. In the older revision such a write has no effect. Bits 3 and 4 are never cleared by a write.
- R6: Writing select code 0 stores the mask, keeping 5 bits (0x1F) in the older revision and 6 bits (0x3F) in the newer one. Reading code 0 returns the stored mask.
- R7: Reading select code 1 returns the stored flags with bit 12 replaced by `bus_busy`. A set pulse on bit 12 is not stored.
- R8: Writing select code 4 (self-test) with bit 11 set forces status bits 0x003F on in the newer revision and does nothing in the older one.
- R9: A set pulse on a flag in the same cycle as a write or a vector read that would clear it leaves the flag set.
- R10: After reset the status, mask and DMA-enable registers are zero, and `irq`, `drq_rx` and `drq_tx` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | 16 | Per-flag set pulses from the bus engine |
| bus_busy | input | 1 | Bus-busy level, merged into status reads |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledges on vector reads) |
| addr | input | 3 | Register select: 0 mask, 1 status, 2 vector, 3 DMA enable, 4 self-test |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from the select code |
| irq | output | 1 | Level interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |

## Verification
Read data is combinational, so the bench samples it in the same cycle the strobe is raised. Register side effects appear on the next edge and are checked by a read that follows. `irq` and the DMA requests lag the registers by one edge. Output checks therefore wait one extra cycle after the write or pulse that changed the state, and one directed test samples `irq` right after a set pulse to confirm it is still low before it rises one cycle later. Both revisions are instantiated side by side and driven with the same stimulus, each against its own expected values.

// File: rtl/irq_status_vector.sv
module irq_status_vector #(
  parameter bit NEW_REV = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] flag_set,
  input  logic        bus_busy,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        drq_rx,
  output logic        drq_tx
);
  localparam logic [2:0]  SEL_MASK = 3'd0;
  localparam logic [2:0]  SEL_STAT = 3'd1;
  localparam logic [2:0]  SEL_VEC  = 3'd2;
  localparam logic [2:0]  SEL_DMA  = 3'd3;
  localparam logic [2:0]  SEL_TEST = 3'd4;
  localparam int          MASK_W   = NEW_REV ? 6 : 5;
  localparam logic [5:0]  MASK_KEEP = 6'((1 << MASK_W) - 1);
  localparam logic [15:0] STAT_KEEP = 16'hEFFF;
  localparam logic [15:0] W1C_KEEP  = 16'h0027;
  localparam logic [15:0] DMA_KEEP  = 16'h8080;
  localparam logic [15:0] TEST_SET  = 16'h003F;

  logic [15:0] stat_q, stat_d, dma_q;
  logic [5:0]  mask_q, mask_d, pend;
  logic [4:0]  vec;

  wire wr_mask = wr_en && addr == SEL_MASK;
  wire wr_stat = wr_en && addr == SEL_STAT;
  wire wr_dma  = wr_en && addr == SEL_DMA;
  wire wr_test = wr_en && addr == SEL_TEST;
  wire vec_ack = rd_en && addr == SEL_VEC && !NEW_REV && vec != 5'd0;

  assign pend = stat_q[5:0] & mask_q;

  always_comb begin
    vec = 5'd0;
    for (int i = 5; i >= 0; i--)
      if (pend[i]) vec = 5'(i + 1);
  end

  always_comb begin
    stat_d = stat_q;
    if (NEW_REV && wr_stat) stat_d = stat_d & ~(wdata & W1C_KEEP);
    if (NEW_REV && wr_test && wdata[11]) stat_d = stat_d | TEST_SET;
    if (vec_ack) stat_d = stat_d & ~(16'd1 << (vec - 5'd1));
    stat_d = stat_d | (flag_set & STAT_KEEP);
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wdata[5:0] & MASK_KEEP;
    if (wr_dma && wdata[15]) mask_d[3] = 1'b0;
    if (wr_dma && wdata[7])  mask_d[4] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      dma_q  <= '0;
      irq    <= 1'b0;
      drq_rx <= 1'b0;
      drq_tx <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      if (wr_dma) dma_q <= wdata & DMA_KEEP;
      irq    <= |pend;
      drq_rx <= dma_q[15] & stat_q[3];
      drq_tx <= dma_q[7] & stat_q[4];
    end
  end

  always_comb begin
    case (addr)
      SEL_MASK: rdata = {10'd0, mask_q};
      SEL_STAT: rdata = stat_q | {3'd0, bus_busy, 12'd0};
      SEL_VEC:  rdata = NEW_REV ? 16'd0 : {11'd0, vec};
      SEL_DMA:  rdata = dma_q;
      default:  rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/irq_status_vector_chk.sv
module irq_status_vector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] flag_set,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        irq,
  input logic        drq_rx,
  input logic        drq_tx,
  input logic [15:0] stat_q,
  input logic [5:0]  mask_q,
  input logic [15:0] dma_q
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == |($past(stat_q[5:0]) & $past(mask_q)));  // R1
  AST_RX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drq_rx == ($past(dma_q[15]) & $past(stat_q[3])));  // R2
  AST_TX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drq_tx == ($past(dma_q[7]) & $past(stat_q[4])));  // R2
  AST_VEC_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && rdata != 16'd0 && flag_set == 16'd0)
      |=> !stat_q[$past(rdata[3:0]) - 4'd1]);  // R3
  AST_DMA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata[15]) |=> !mask_q[3]);  // R4
  AST_RDY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !(rd_en && addr == 3'd2)) |=> stat_q[3]);  // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & $past(flag_set & 16'hEFFF)) == $past(flag_set & 16'hEFFF));  // R9
endmodule

bind irq_status_vector irq_status_vector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .drq_rx(drq_rx),
  .drq_tx(drq_tx), .stat_q(stat_q), .mask_q(mask_q), .dma_q(dma_q)
);

// File: tb/test_irq_status_vector.sv
module test_irq_status_vector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] flag_set = '0;
  logic bus_busy = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_a, rdata_b;
  logic irq_a, drq_rx_a, drq_tx_a, irq_b, drq_rx_b, drq_tx_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_vector #(.NEW_REV(1'b0)) i_irq_status_vector (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .bus_busy(bus_busy),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata_a),
    .irq(irq_a), .drq_rx(drq_rx_a), .drq_tx(drq_tx_a));

  irq_status_vector #(.NEW_REV(1'b1)) i_irq_status_vector_new (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .bus_busy(bus_busy),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata_b),
    .irq(irq_b), .drq_rx(drq_rx_b), .drq_tx(drq_tx_b));

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PULSE = 2'd2, OP_OUT = 2'd3;
  localparam int NSTEP = 27;
  // {op, select, data, expected older rev, expected newer rev}
  localparam logic [52:0] STEPS [NSTEP] = '{
    {OP_WR,    3'd0, 16'h003F, 16'h0000, 16'h0000},
    {OP_RD,    3'd0, 16'h0000, 16'h001F, 16'h003F},
    {OP_PULSE, 3'd0, 16'h0024, 16'h0000, 16'h0000},
    {OP_OUT,   3'd0, 16'h0000, 16'h0004, 16'h0004},
    {OP_RD,    3'd1, 16'h0000, 16'h0024, 16'h0024},
    {OP_RD,    3'd2, 16'h0000, 16'h0003, 16'h0000},
    {OP_RD,    3'd1, 16'h0000, 16'h0020, 16'h0024},
    {OP_OUT,   3'd0, 16'h0000, 16'h0000, 16'h0004},
    {OP_WR,    3'd1, 16'h003F, 16'h0000, 16'h0000},
    {OP_RD,    3'd1, 16'h0000, 16'h0020, 16'h0000},
    {OP_OUT,   3'd0, 16'h0000, 16'h0000, 16'h0000},
    {OP_PULSE, 3'd0, 16'h0018, 16'h0000, 16'h0000},
    {OP_WR,    3'd3, 16'hFFFF, 16'h0000, 16'h0000},
    {OP_RD,    3'd3, 16'h0000, 16'h8080, 16'h8080},
    {OP_RD,    3'd0, 16'h0000, 16'h0007, 16'h0027},
    {OP_OUT,   3'd0, 16'h0000, 16'h0003, 16'h0003},
    {OP_WR,    3'd1, 16'h0018, 16'h0000, 16'h0000},
    {OP_RD,    3'd1, 16'h0000, 16'h0038, 16'h0018},
    {OP_WR,    3'd3, 16'h0000, 16'h0000, 16'h0000},
    {OP_OUT,   3'd0, 16'h0000, 16'h0000, 16'h0000},
    {OP_WR,    3'd4, 16'h0800, 16'h0000, 16'h0000},
    {OP_RD,    3'd1, 16'h0000, 16'h0038, 16'h003F},
    {OP_WR,    3'd0, 16'h0030, 16'h0000, 16'h0000},
    {OP_RD,    3'd2, 16'h0000, 16'h0005, 16'h0000},
    {OP_RD,    3'd1, 16'h0000, 16'h0028, 16'h003F},
    {OP_RD,    3'd2, 16'h0000, 16'h0000, 16'h0000},
    {OP_OUT,   3'd0, 16'h0000, 16'h0000, 16'h0004}
  };
  string tags [NSTEP] = '{"R6", "R6", "R1", "R1", "R7", "R3", "R3", "R1", "R5",
    "R5", "R1", "R2", "R4", "R4", "R4", "R2", "R5", "R5", "R2", "R2", "R8",
    "R8", "R6", "R3", "R3", "R3", "R1"};

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] va, output logic [15:0] vb);
    rd_en = 1'b1; addr = a;
    #1 va = rdata_a; vb = rdata_b;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] f);
    flag_set = f;
    @(negedge clk);
    flag_set = '0;
  endtask

  function automatic logic [15:0] outs_a();
    return {13'd0, irq_a, drq_rx_a, drq_tx_a};
  endfunction
  function automatic logic [15:0] outs_b();
    return {13'd0, irq_b, drq_rx_b, drq_tx_b};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] va, vb;
    do_reset();
    // R10: reset state
    chk("R10", "outputs old", outs_a(), 16'h0);
    chk("R10", "outputs new", outs_b(), 16'h0);
    rd(3'd1, va, vb);
    chk("R10", "status old", va, 16'h0);
    chk("R10", "status new", vb, 16'h0);
    rd(3'd0, va, vb);
    chk("R10", "mask old", va, 16'h0);
    chk("R10", "mask new", vb, 16'h0);

    for (int s = 0; s < NSTEP; s++) begin
      logic [52:0] e;
      e = STEPS[s];
      case (e[52:51])
        OP_WR: wr(e[50:48], e[47:32]);
        OP_PULSE: pulse(e[47:32]);
        OP_RD: begin
          rd(e[50:48], va, vb);
          chk(tags[s], $sformatf("step %0d old read", s), va, e[31:16]);
          chk(tags[s], $sformatf("step %0d new read", s), vb, e[15:0]);
        end
        default: begin
          @(negedge clk);
          chk(tags[s], $sformatf("step %0d old outputs", s), outs_a(), e[31:16]);
          chk(tags[s], $sformatf("step %0d new outputs", s), outs_b(), e[15:0]);
        end
      endcase
    end

    do_reset();
    wr(3'd0, 16'h001F);
    pulse(16'h0003);
    // R1: irq must not rise until one edge after the status register changes
    chk("R1", "irq before lag", {15'd0, irq_a}, 16'h0);
    @(negedge clk);
    chk("R1", "irq after lag", {15'd0, irq_a}, 16'h1);
    // R3: lowest index first, then empty
    rd(3'd2, va, vb);
    chk("R3", "vector first", va, 16'h0001);
    rd(3'd2, va, vb);
    chk("R3", "vector second", va, 16'h0002);
    rd(3'd2, va, vb);
    chk("R3", "vector empty", va, 16'h0000);
    // R9: set pulse beats vector acknowledge
    pulse(16'h0001);
    flag_set = 16'h0001; rd_en = 1'b1; addr = 3'd2;
    #1 chk("R9", "vector value", rdata_a, 16'h0001);
    @(negedge clk);
    flag_set = '0; rd_en = 1'b0;
    rd(3'd1, va, vb);
    chk("R9", "old status kept", va, 16'h0001);
    chk("R9", "new status", vb, 16'h0003);
    // R9: set pulse beats write-one-to-clear
    flag_set = 16'h0001;
    wr(3'd1, 16'h0003);
    flag_set = '0;
    rd(3'd1, va, vb);
    chk("R9", "new status after clear", vb, 16'h0001);
    // R7: busy merged into bit 12, pulses on bit 12 not stored
    bus_busy = 1'b1;
    rd(3'd1, va, vb);
    chk("R7", "busy old", va, 16'h1001);
    chk("R7", "busy new", vb, 16'h1001);
    bus_busy = 1'b0;
    pulse(16'h1000);
    rd(3'd1, va, vb);
    chk("R7", "bit12 pulse old", va, 16'h0001);
    chk("R7", "bit12 pulse new", vb, 16'h0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule